// File: doc/BRIEF.md
# Bidirectional GPIO Port with Peripheral Overrides

This block controls an 8-bit bidirectional I/O port from a small memory-mapped register bus. Software sets a direction mask and an output latch; each pad is modelled as three vectors: output enable, output value and sensed input. The sensed pad levels pass through a two-stage synchronizer before software can read them. A read of the output latch returns the stored drive value and never the pad level, so a read-modify-write on the latch gives the same result whatever the pads are doing.

Peripherals can take over individual pins with a per-pin override enable. While an override is active, the peripheral's enable and value drive the pad, and the stored direction bits are left untouched. A single routing input decides where one relocatable peripheral signal lands. When the input is high, the signal uses a chosen pin of this port. When it is low, the signal goes to a pin on a neighbouring port, which is exposed here as a separate one-bit pad.

Top module: `gpio_port`

## Requirements
- R1: During and just after reset the direction register reads all ones, the output latch reads zero and every `pad_oe` bit is 0.
- R2: On a pin with no active override, `pad_oe` is the inverse of its direction bit (0 = drive, 1 = input), and `pad_out` equals its output latch bit.
- R3: A bus read at address 1 returns the output latch contents, whatever levels are present on `pad_in`.
- R4: A bus read at address 0 returns `pad_in` after two clock edges. A level applied before edge k becomes readable after edge k+1, and is not yet readable after edge k.
- R5: A write at address 0 or at address 1 loads `bus_wdata` into the output latch at the clock edge that samples `bus_wr`. Writing zero to either address clears the latch.
- R6: While `ovr_en[i]` is 1 and the pin is not taken by the relocatable peripheral, `pad_oe[i]` equals `ovr_oe[i]` and `pad_out[i]` equals `ovr_out[i]`. This can force a pin to input or to output.
- R7: A write at address 2 loads the direction register. A read at address 2 returns the stored direction value, even while overrides are changing the pads.
- R8: When `route_sel` is 1 and `rp_en` is 1, pin RELOC_PIN (default 1) is driven by `rp_oe`/`rp_out`, which take precedence over `ovr_en` on that pin. `alt_oe` is then 0, and `rp_in` is the synchronized `pad_in[RELOC_PIN]`.
- R9: When `route_sel` is 0, `alt_oe`/`alt_out` equal `rp_oe`/`rp_out` while `rp_en` is 1 and are 0 otherwise. Pin RELOC_PIN behaves like any other pin, and `rp_in` is `alt_in` after two clock edges.
- R10: Address 3 reads as zero, and a write to it changes neither the latch nor the direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address: 0 pins, 1 latch, 2 direction |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| ovr_en | input | 8 | Per-pin peripheral override enable |
| ovr_oe | input | 8 | Override output enable |
| ovr_out | input | 8 | Override output value |
| route_sel | input | 1 | 1 places the relocatable signal on this port, 0 on the alternate pad |
| rp_en | input | 1 | Relocatable peripheral active |
| rp_oe | input | 1 | Relocatable peripheral output enable |
| rp_out | input | 1 | Relocatable peripheral output value |
| rp_in | output | 1 | Synchronized input seen by the relocatable peripheral |
| pad_oe | output | 8 | Pad output enables |
| pad_out | output | 8 | Pad output values |
| pad_in | input | 8 | Pad input levels |
| alt_oe | output | 1 | Alternate pad output enable |
| alt_out | output | 1 | Alternate pad output value |
| alt_in | input | 1 | Alternate pad input level |

## Verification
A corrupted direction or latch bit shows up on `pad_oe` or `pad_out` in the cycle after the write that caused it, and on the matching bus readback at once. A synchronizer that has a stage too many or too few moves the port readback and `rp_in` by one edge. The bench catches this by sampling after exactly one edge and again after two. A routing or override mux that picks the wrong source changes the pads combinationally, and the next sample shows it. An override that leaks into the stored state shows up only when the direction register is read back, so the bench reads it while overrides are active.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_PINS  = 2'd0,
        SEL_LATCH = 2'd1,
        SEL_DIR   = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.meta   = din;
        sync_d.stable = sync_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q.stable;

    // R4: each stage takes the previous one a single edge later
    a_r4_first_stage: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> sync_q.meta == $past(din));
    a_r4_second_stage: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> sync_q.stable == $past(sync_q.meta));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic [WIDTH-1:0]  pins_sync,
    output logic [WIDTH-1:0]  bus_rdata,
    output logic [WIDTH-1:0]  dir_o,
    output logic [WIDTH-1:0]  lat_o
);
    typedef struct packed {
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] lat;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  hit_lat, hit_dir;

    always_comb begin
        hit_lat = bus_wr && (bus_addr == SEL_PINS || bus_addr == SEL_LATCH);
        hit_dir = bus_wr && (bus_addr == SEL_DIR);
        regs_d  = regs_q;
        if (hit_lat) regs_d.lat = bus_wdata;
        if (hit_dir) regs_d.dir = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.dir <= '1;
            regs_q.lat <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        unique case (bus_addr)
            SEL_PINS:  bus_rdata = pins_sync;
            SEL_LATCH: bus_rdata = regs_q.lat;
            SEL_DIR:   bus_rdata = regs_q.dir;
            default:   bus_rdata = '0;
        endcase
    end

    assign dir_o = regs_q.dir;
    assign lat_o = regs_q.lat;

    a_r1_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (regs_q.dir == '1 && regs_q.lat == '0));
    a_r5_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == SEL_PINS || bus_addr == SEL_LATCH))
            |=> regs_q.lat == $past(bus_wdata));
    a_r7_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SEL_DIR) |=> regs_q.dir == $past(bus_wdata));
    a_r7_dir_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == SEL_DIR) |=> $stable(regs_q.dir));
    a_r10_none_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SEL_NONE) |=> ($stable(regs_q.dir) && $stable(regs_q.lat)));
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
    parameter int WIDTH     = 8,
    parameter int RELOC_PIN = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] lat,
    input  logic [WIDTH-1:0] ovr_en,
    input  logic [WIDTH-1:0] ovr_oe,
    input  logic [WIDTH-1:0] ovr_out,
    input  logic             route_sel,
    input  logic             rp_en,
    input  logic             rp_oe,
    input  logic             rp_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic             alt_oe,
    output logic             alt_out
);
    logic rp_local;

    assign rp_local = route_sel && rp_en;

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        logic claimed;
        if (i == RELOC_PIN) begin : g_reloc
            assign claimed = rp_local;
        end else begin : g_plain
            assign claimed = 1'b0;
        end

        always_comb begin
            if (claimed) begin
                pad_oe[i]  = rp_oe;
                pad_out[i] = rp_out;
            end else if (ovr_en[i]) begin
                pad_oe[i]  = ovr_oe[i];
                pad_out[i] = ovr_out[i];
            end else begin
                pad_oe[i]  = ~dir[i];
                pad_out[i] = lat[i];
            end
        end

        a_r2_register_drive: assert property (@(posedge clk) disable iff (!rst_n)
            (!claimed && !ovr_en[i]) |-> (pad_oe[i] != dir[i] && pad_out[i] == lat[i]));
        a_r6_override_drive: assert property (@(posedge clk) disable iff (!rst_n)
            (!claimed && ovr_en[i]) |-> (pad_oe[i] == ovr_oe[i] && pad_out[i] == ovr_out[i]));
    end

    always_comb begin
        alt_oe  = 1'b0;
        alt_out = 1'b0;
        if (!route_sel && rp_en) begin
            alt_oe  = rp_oe;
            alt_out = rp_out;
        end
    end

    a_r8_local_route: assert property (@(posedge clk) disable iff (!rst_n)
        (route_sel && rp_en) |-> (pad_oe[RELOC_PIN] == rp_oe && pad_out[RELOC_PIN] == rp_out && !alt_oe));
    a_r9_alt_route: assert property (@(posedge clk) disable iff (!rst_n)
        !route_sel |-> (alt_oe == (rp_en && rp_oe) && alt_out == (rp_en && rp_out)));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int WIDTH     = 8,
    parameter int RELOC_PIN = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  ovr_en,
    input  logic [WIDTH-1:0]  ovr_oe,
    input  logic [WIDTH-1:0]  ovr_out,
    input  logic              route_sel,
    input  logic              rp_en,
    input  logic              rp_oe,
    input  logic              rp_out,
    output logic              rp_in,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_out,
    input  logic [WIDTH-1:0]  pad_in,
    output logic              alt_oe,
    output logic              alt_out,
    input  logic              alt_in
);
    localparam int SYNC_W = WIDTH + 1;
    localparam int ALT_IX = WIDTH;

    logic [SYNC_W-1:0] sync_out;
    logic [WIDTH-1:0]  dir_w, lat_w;

    gpio_sync #(.WIDTH(SYNC_W)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({alt_in, pad_in}),
        .dout (sync_out)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .pins_sync(sync_out[WIDTH-1:0]),
        .bus_rdata(bus_rdata),
        .dir_o    (dir_w),
        .lat_o    (lat_w)
    );

    gpio_pad_mux #(.WIDTH(WIDTH), .RELOC_PIN(RELOC_PIN)) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .dir      (dir_w),
        .lat      (lat_w),
        .ovr_en   (ovr_en),
        .ovr_oe   (ovr_oe),
        .ovr_out  (ovr_out),
        .route_sel(route_sel),
        .rp_en    (rp_en),
        .rp_oe    (rp_oe),
        .rp_out   (rp_out),
        .pad_oe   (pad_oe),
        .pad_out  (pad_out),
        .alt_oe   (alt_oe),
        .alt_out  (alt_out)
    );

    assign rp_in = route_sel ? sync_out[RELOC_PIN] : sync_out[ALT_IX];

    a_r1_pads_released: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n) && ovr_en == '0 && !(route_sel && rp_en)) |-> pad_oe == '0);
endmodule

// File: tb/gpio_port_bench.sv
module gpio_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] ovr_en = 8'h00, ovr_oe = 8'h00, ovr_out = 8'h00;
    logic       route_sel = 1'b1, rp_en = 1'b0, rp_oe = 1'b0, rp_out = 1'b0;
    logic       rp_in;
    logic [7:0] pad_oe, pad_out;
    logic [7:0] pad_in = 8'h00;
    logic       alt_oe, alt_out;
    logic       alt_in = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    gpio_port u_gpio_port (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ovr_en(ovr_en), .ovr_oe(ovr_oe), .ovr_out(ovr_out),
        .route_sel(route_sel), .rp_en(rp_en), .rp_oe(rp_oe), .rp_out(rp_out), .rp_in(rp_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_in(pad_in),
        .alt_oe(alt_oe), .alt_out(alt_out), .alt_in(alt_in)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(2'd2, v); check("R1 dir reset", v, 8'hFF);
        rd(2'd1, v); check("R1 latch reset", v, 8'h00);
        check("R1 pad_oe reset", pad_oe, 8'h00);
    endtask

    task automatic t_direction();
        wr(2'd1, 8'hA5);
        wr(2'd2, 8'hCF);
        #1;
        check("R2 pad_oe from dir", pad_oe, 8'h30);
        check("R2 pad_out from latch", pad_out, 8'hA5);
        begin
            logic [7:0] v;
            rd(2'd2, v); check("R7 dir readback", v, 8'hCF);
        end
    endtask

    task automatic t_latch_vs_pins();
        logic [7:0] v;
        @(negedge clk); pad_in = 8'h0F;
        @(negedge clk);
        rd(2'd0, v); check("R4 one edge not yet", v, 8'h00);
        rd(2'd1, v); check("R3 latch ignores pins", v, 8'hA5);
        @(negedge clk);
        rd(2'd0, v); check("R4 two edges visible", v, 8'h0F);
    endtask

    task automatic t_port_write();
        logic [7:0] v;
        wr(2'd0, 8'h3C);
        rd(2'd1, v); check("R5 write via pins addr", v, 8'h3C);
        #1; check("R5 pad_out follows", pad_out, 8'h3C);
        wr(2'd1, 8'h00);
        rd(2'd1, v); check("R5 clear via latch addr", v, 8'h00);
        wr(2'd0, 8'h77);
        wr(2'd0, 8'h00);
        rd(2'd1, v); check("R5 clear via pins addr", v, 8'h00);
    endtask

    task automatic t_override();
        logic [7:0] v;
        route_sel = 1'b0; rp_en = 1'b0;
        wr(2'd2, 8'hFF);
        @(negedge clk);
        ovr_en = 8'h81; ovr_oe = 8'h01; ovr_out = 8'h81;
        #1;
        check("R6 force output", pad_oe, 8'h01);
        check("R6 override value", pad_out, 8'h81);
        rd(2'd2, v); check("R7 dir unchanged by override", v, 8'hFF);
        wr(2'd2, 8'h00);
        @(negedge clk);
        ovr_en = 8'hF0; ovr_oe = 8'h00; ovr_out = 8'h00;
        #1;
        check("R6 force input", pad_oe, 8'h0F);
        rd(2'd2, v); check("R7 dir readback under override", v, 8'h00);
        @(negedge clk);
        ovr_en = 8'h00;
        #1;
        check("R2 release override", pad_oe, 8'hFF);
    endtask

    task automatic t_reloc();
        @(negedge clk);
        wr(2'd2, 8'hFF);
        @(negedge clk);
        pad_in = 8'h02; alt_in = 1'b0;
        route_sel = 1'b1; rp_en = 1'b1; rp_oe = 1'b1; rp_out = 1'b1;
        ovr_en = 8'h02; ovr_oe = 8'h00; ovr_out = 8'h00;
        #1;
        check("R8 pin1 oe", {7'b0, pad_oe[1]}, 8'h01);
        check("R8 pin1 out", {7'b0, pad_out[1]}, 8'h01);
        check("R8 alt idle", {7'b0, alt_oe}, 8'h00);
        @(negedge clk); @(negedge clk);
        check("R8 rp_in from pin1", {7'b0, rp_in}, 8'h01);
        route_sel = 1'b0;
        #1;
        check("R9 alt oe", {6'b0, alt_oe, alt_out}, 8'h03);
        check("R9 pin1 back to override", {6'b0, pad_oe[1], pad_out[1]}, 8'h00);
        check("R9 rp_in from alt", {7'b0, rp_in}, 8'h00);
        @(negedge clk); alt_in = 1'b1;
        @(negedge clk);
        check("R9 alt one edge", {7'b0, rp_in}, 8'h00);
        @(negedge clk);
        check("R9 alt two edges", {7'b0, rp_in}, 8'h01);
        rp_en = 1'b0;
        #1;
        check("R9 alt off without rp_en", {6'b0, alt_oe, alt_out}, 8'h00);
        ovr_en = 8'h00;
    endtask

    task automatic t_unused_addr();
        logic [7:0] v;
        wr(2'd1, 8'h5A);
        wr(2'd2, 8'hC3);
        wr(2'd3, 8'h55);
        rd(2'd3, v); check("R10 addr3 reads zero", v, 8'h00);
        rd(2'd1, v); check("R10 latch kept", v, 8'h5A);
        rd(2'd2, v); check("R10 dir kept", v, 8'hC3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direction();
        t_latch_vs_pins();
        t_port_write();
        t_override();
        t_reloc();
        t_unused_addr();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule